// File: doc/BRIEF.md
# Serial Configuration Register Bank with Readback

This block is the control-port front end of a frequency synthesizer. A host drives three pins: a serial clock, a data line and a load strobe. While the strobe is low, each rising serial clock edge shifts one bit into a 32-bit frame, most significant bit first. When the strobe rises, the frame is committed. The three low bits of the frame select one of five read-write configuration words. The 28 bits above them carry the word contents. Bit 31 is a read flag.

All three pins are asynchronous to the system clock. They pass through synchronizer stages, and edges are detected on the synchronized copies. The configuration words are decoded into the fields the synthesizer uses. The reference-divider, doubler, halver and modulus fields are staged in the written words. They reach the active outputs only when word 0 is written, so that one write applies a whole new divider setting at once.

A frame with the read flag set changes nothing. It arms a readback of the addressed word, which then leaves the block on a shared output pin, one bit per following serial clock edge. That pin is also a test output. A 4-bit selector held in word 0 picks what drives it. Address 6 is a read-only status word holding a power-on flag and a 7-bit converter result.

Top module: `cfg_serial_bank`

## Requirements
- R1: A 32-bit frame shifted while `sload_i` is low is committed on the rising edge of `sload_i` into the word at address frame[2:0] (0 to 4), storing frame[30:3]; a later readback of that word returns exactly those bits.
- R2: Decoded fields follow the stored words immediately after commit: `int_div_o` = {word1 frame bits 30:27, word0 frame bits 26:15}, `frac_o` = word0 frame bits 14:3, `phase_o` = word1 frame bits 14:3, `prescale_o` = word1 frame bit 25.
- R3: `ref_div_o` = {word1 bits 19:15, word2 bits 19:15}, `ref_dbl_o` = word2 bit 20, `ref_half_o` = word2 bit 21 and `modulus_o` = word2 bits 14:3 change only on a commit to address 0, which copies the current staged values.
- R4: A frame with bit 31 = 1 leaves every stored word and decoded output unchanged, whatever bits 30:3 hold.
- R5: After a read frame to address 0 to 4 or 6, with the selector at 0111, the first rising serial clock edge puts a 0 (bit 31 position) on `mux_o`. Each of the next 28 rising edges puts the next lower bit (30 down to 3) on `mux_o`. After that, `mux_o` holds.
- R6: Address 6 reads back bit 11 = power-on flag, bit 10 = `adc_vld_i`, bits 9:3 = `adc_i`, and 0 in every other bit position.
- R7: The power-on flag is 1 after reset, and it becomes 0 once address 6 has been read; it never returns to 1 without reset.
- R8: Frames addressed to 5 or 7, and write frames addressed to 6, change no stored word or output.
- R9: Selector word0 bits 30:27 drives `mux_oe_o` low for 0000, and `mux_o` = 1 for 0001, 0 for 0010, `rdiv_i` for 0011, `ndiv_i` for 0100, `lock_i` for 0101/0110, readback for 0111, `fastlock_i` for 1100. The reserved codes and 1000 also drive `mux_oe_o` low.
- R10: Selectors 1101 and 1110 output a signal that toggles once per rising edge of `rdiv_i` and `ndiv_i` respectively.
- R11: After reset all words are zero, all decoded outputs are zero and `mux_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| sload_i | input | 1 | Load strobe; rising edge commits the frame |
| adc_i | input | 7 | Converter result for the status word |
| adc_vld_i | input | 1 | Converter result valid |
| rdiv_i | input | 1 | Reference divider output (system-clock synchronous) |
| ndiv_i | input | 1 | Feedback divider output (system-clock synchronous) |
| lock_i | input | 1 | Lock detect |
| fastlock_i | input | 1 | Fast-lock switch state |
| mux_o | output | 1 | Shared test / readback output |
| mux_oe_o | output | 1 | Output enable for `mux_o` |
| int_div_o | output | 16 | Integer divide value |
| frac_o | output | 12 | Fractional value |
| phase_o | output | 12 | Phase value |
| prescale_o | output | 1 | Input prescaler select |
| ref_div_o | output | 10 | Active reference divide value |
| ref_dbl_o | output | 1 | Active reference doubler enable |
| ref_half_o | output | 1 | Active reference halver enable |
| modulus_o | output | 12 | Active fractional modulus |
| sd_mode_o | output | 2 | Modulator noise mode (word2 bits 30:29) |
| slip_red_o | output | 1 | Cycle-slip reduction enable (word2 bit 28) |
| cp_cur_o | output | 4 | Charge-pump current code (word2 bits 27:24) |
| ctl3_o | output | 28 | Word 3 contents, frame bits 30:3 |
| ctl4_o | output | 28 | Word 4 contents, frame bits 30:3 |

## Verification
The properties assume that `rdiv_i` and `ndiv_i` are already synchronous to the system clock. They also assume that the serial pins stay steady for several system clocks around each edge, so that the synchronizers show each serial edge exactly once. The bench holds every serial phase for four system clocks and changes data only while the serial clock is low. It pulses the divider inputs for several cycles at a time. Serial clock edges are never issued while the load strobe is high, and a new frame is not started until a pending readback has been fully clocked out.

// File: rtl/cfgsb_pkg.sv
package cfgsb_pkg;
  localparam int FRAME_W   = 32;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = FRAME_W - ADDR_W - 1;
  localparam int RB_W      = DATA_W + 1;
  localparam int NUM_RW    = 5;
  localparam int STAT_ADDR = 6;
  localparam int ADC_W     = 7;
  localparam int SEL_W     = 4;
  localparam int RDIV_W    = 10;
  localparam int RHALF_W   = RDIV_W / 2;
  localparam int NDIV_W    = 16;
  localparam int NLO_W     = 12;
  localparam int FRAC_W    = 12;

  typedef enum logic [SEL_W-1:0] {
    SEL_HIZ   = 4'b0000,
    SEL_HI    = 4'b0001,
    SEL_LO    = 4'b0010,
    SEL_RDIV  = 4'b0011,
    SEL_NDIV  = 4'b0100,
    SEL_ALOCK = 4'b0101,
    SEL_DLOCK = 4'b0110,
    SEL_SPI   = 4'b0111,
    SEL_SYNC  = 4'b1000,
    SEL_FAST  = 4'b1100,
    SEL_RHALF = 4'b1101,
    SEL_NHALF = 4'b1110
  } mux_sel_e;
endpackage

// File: rtl/cfgsb_front.sv
module cfgsb_front
  import cfgsb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               sload_i,
  output logic               sclk_rise_o,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_q, sdat_q, sld_q;
  logic                   sclk_d, sld_d;
  logic [FRAME_W-1:0]     shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      sdat_q <= '0;
      sld_q  <= '0;
      sclk_d <= 1'b0;
      sld_d  <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[MSB-1:0], sclk_i};
      sdat_q <= {sdat_q[MSB-1:0], sdata_i};
      sld_q  <= {sld_q[MSB-1:0], sload_i};
      sclk_d <= sclk_q[MSB];
      sld_d  <= sld_q[MSB];
    end
  end

  assign sclk_rise_o = sclk_q[MSB] & ~sclk_d;
  assign frame_vld_o = sld_q[MSB] & ~sld_d;
  assign frame_o     = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else if (sclk_rise_o && !sld_q[MSB]) shift_q <= {shift_q[FRAME_W-2:0], sdat_q[MSB]};
  end
endmodule

// File: rtl/cfgsb_regs.sv
module cfgsb_regs
  import cfgsb_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          frame_vld_i,
  input  logic [FRAME_W-1:0]            frame_i,
  input  logic [ADC_W-1:0]              adc_i,
  input  logic                          adc_vld_i,
  output logic [NUM_RW-1:0][DATA_W-1:0] words_o,
  output logic [RDIV_W-1:0]             ref_div_o,
  output logic                          ref_dbl_o,
  output logic                          ref_half_o,
  output logic [FRAC_W-1:0]             modulus_o,
  output logic                          wr0_o,
  output logic                          rd_req_o,
  output logic [RB_W-1:0]               rd_word_o,
  output logic                          por_o
);
  // frame bit positions minus ADDR_W
  localparam int RLO_LSB = 15 - ADDR_W;
  localparam int DBL_B   = 20 - ADDR_W;
  localparam int HALF_B  = 21 - ADDR_W;
  localparam int PAD_W   = DATA_W - 2 - ADC_W;

  logic [ADDR_W-1:0] addr;
  logic              is_rd, is_wr;
  logic [DATA_W-1:0] data;
  logic [DATA_W-1:0] word_q [NUM_RW];
  logic [DATA_W-1:0] sel_word;
  logic              por_q;

  assign addr  = frame_i[ADDR_W-1:0];
  assign is_rd = frame_i[FRAME_W-1];
  assign is_wr = frame_vld_i & ~is_rd;
  assign data  = frame_i[FRAME_W-2:ADDR_W];
  assign wr0_o = is_wr && (addr == '0);

  for (genvar g = 0; g < NUM_RW; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[g] <= '0;
      else if (is_wr && addr == ADDR_W'(g)) word_q[g] <= data;
    end
    assign words_o[g] = word_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_div_o  <= '0;
      ref_dbl_o  <= 1'b0;
      ref_half_o <= 1'b0;
      modulus_o  <= '0;
    end else if (wr0_o) begin
      ref_div_o  <= {word_q[1][RLO_LSB +: RHALF_W], word_q[2][RLO_LSB +: RHALF_W]};
      ref_dbl_o  <= word_q[2][DBL_B];
      ref_half_o <= word_q[2][HALF_B];
      modulus_o  <= word_q[2][FRAC_W-1:0];
    end
  end

  assign rd_req_o = frame_vld_i && is_rd &&
                    ((int'(addr) < NUM_RW) || (int'(addr) == STAT_ADDR));

  always_comb begin
    sel_word = '0;
    if (int'(addr) == STAT_ADDR) begin
      sel_word = {{PAD_W{1'b0}}, por_q, adc_vld_i, adc_i};
    end else begin
      for (int i = 0; i < NUM_RW; i++)
        if (addr == ADDR_W'(i)) sel_word = word_q[i];
    end
  end

  assign rd_word_o = {1'b0, sel_word};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) por_q <= 1'b1;
    else if (rd_req_o && int'(addr) == STAT_ADDR) por_q <= 1'b0;
  end

  assign por_o = por_q;
endmodule

// File: rtl/cfgsb_rdback.sv
module cfgsb_rdback
  import cfgsb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_req_i,
  input  logic [RB_W-1:0] rd_word_i,
  input  logic            sclk_rise_i,
  output logic            bit_o
);
  localparam int CNT_W = $clog2(RB_W + 1);

  logic [RB_W-1:0]  word_q;
  logic [CNT_W-1:0] left_q;
  logic             bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      left_q <= '0;
      bit_q  <= 1'b0;
    end else if (rd_req_i) begin
      word_q <= rd_word_i;
      left_q <= CNT_W'(RB_W);
    end else if (sclk_rise_i && left_q != '0) begin
      bit_q  <= word_q[RB_W-1];
      word_q <= {word_q[RB_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/cfgsb_outmux.sv
module cfgsb_outmux
  import cfgsb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rdiv_i,
  input  logic             ndiv_i,
  input  logic             lock_i,
  input  logic             fastlock_i,
  input  logic             rb_bit_i,
  output logic             mux_o,
  output logic             mux_oe_o,
  output logic [1:0]       half_o
);
  logic [1:0] src;
  assign src = {ndiv_i, rdiv_i};

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic src_d, tog_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_d <= 1'b0;
        tog_q <= 1'b0;
      end else begin
        src_d <= src[g];
        if (src[g] && !src_d) tog_q <= ~tog_q;
      end
    end
    assign half_o[g] = tog_q;
  end

  always_comb begin
    mux_o    = 1'b0;
    mux_oe_o = 1'b1;
    unique case (mux_sel_e'(sel_i))
      SEL_HI:    mux_o = 1'b1;
      SEL_LO:    mux_o = 1'b0;
      SEL_RDIV:  mux_o = rdiv_i;
      SEL_NDIV:  mux_o = ndiv_i;
      SEL_ALOCK,
      SEL_DLOCK: mux_o = lock_i;
      SEL_SPI:   mux_o = rb_bit_i;
      SEL_FAST:  mux_o = fastlock_i;
      SEL_RHALF: mux_o = half_o[0];
      SEL_NHALF: mux_o = half_o[1];
      default:   mux_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank
  import cfgsb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               sload_i,
  input  logic [ADC_W-1:0]   adc_i,
  input  logic               adc_vld_i,
  input  logic               rdiv_i,
  input  logic               ndiv_i,
  input  logic               lock_i,
  input  logic               fastlock_i,
  output logic               mux_o,
  output logic               mux_oe_o,
  output logic [NDIV_W-1:0]  int_div_o,
  output logic [FRAC_W-1:0]  frac_o,
  output logic [FRAC_W-1:0]  phase_o,
  output logic               prescale_o,
  output logic [RDIV_W-1:0]  ref_div_o,
  output logic               ref_dbl_o,
  output logic               ref_half_o,
  output logic [FRAC_W-1:0]  modulus_o,
  output logic [1:0]         sd_mode_o,
  output logic               slip_red_o,
  output logic [3:0]         cp_cur_o,
  output logic [DATA_W-1:0]  ctl3_o,
  output logic [DATA_W-1:0]  ctl4_o
);
  localparam int NHI_W = NDIV_W - NLO_W;

  logic                          sclk_rise, frame_vld, wr0, rd_req, por, rb_bit;
  logic [FRAME_W-1:0]            frame_w;
  logic [NUM_RW-1:0][DATA_W-1:0] words;
  logic [RB_W-1:0]               rd_word;
  logic [SEL_W-1:0]              mux_sel;
  logic [1:0]                    half;

  cfgsb_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .sclk_i, .sdata_i, .sload_i,
    .sclk_rise_o (sclk_rise),
    .frame_vld_o (frame_vld),
    .frame_o     (frame_w)
  );

  cfgsb_regs u_regs (
    .clk_i, .rst_ni,
    .frame_vld_i (frame_vld),
    .frame_i     (frame_w),
    .adc_i, .adc_vld_i,
    .words_o     (words),
    .ref_div_o, .ref_dbl_o, .ref_half_o, .modulus_o,
    .wr0_o       (wr0),
    .rd_req_o    (rd_req),
    .rd_word_o   (rd_word),
    .por_o       (por)
  );

  cfgsb_rdback u_rdback (
    .clk_i, .rst_ni,
    .rd_req_i    (rd_req),
    .rd_word_i   (rd_word),
    .sclk_rise_i (sclk_rise),
    .bit_o       (rb_bit)
  );

  // word fields, frame bit minus ADDR_W
  assign mux_sel    = words[0][DATA_W-1 -: SEL_W];
  assign int_div_o  = {words[1][DATA_W-1 -: NHI_W], words[0][FRAC_W +: NLO_W]};
  assign frac_o     = words[0][FRAC_W-1:0];
  assign phase_o    = words[1][FRAC_W-1:0];
  assign prescale_o = words[1][25-ADDR_W];
  assign sd_mode_o  = words[2][DATA_W-1 -: 2];
  assign slip_red_o = words[2][28-ADDR_W];
  assign cp_cur_o   = words[2][24-ADDR_W +: 4];
  assign ctl3_o     = words[3];
  assign ctl4_o     = words[4];

  cfgsb_outmux u_outmux (
    .clk_i, .rst_ni,
    .sel_i      (mux_sel),
    .rdiv_i, .ndiv_i, .lock_i, .fastlock_i,
    .rb_bit_i   (rb_bit),
    .mux_o, .mux_oe_o,
    .half_o     (half)
  );
endmodule

// File: rtl/cfgsb_chk.sv
module cfgsb_chk
  import cfgsb_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_vld_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic               wr0_i,
  input logic [SEL_W-1:0]   sel_i,
  input logic               por_i,
  input logic [1:0]         half_i,
  input logic               rdiv_i,
  input logic               ndiv_i,
  input logic [RDIV_W-1:0]  ref_div_i,
  input logic [FRAC_W-1:0]  modulus_i,
  input logic [NDIV_W-1:0]  int_div_i,
  input logic [FRAC_W-1:0]  phase_i,
  input logic [DATA_W-1:0]  ctl3_i,
  input logic [DATA_W-1:0]  ctl4_i,
  input logic               mux_oe_i
);
  logic bad_addr;
  assign bad_addr = frame_vld_i && ((frame_i[2:0] == 3'd5) || (frame_i[2:0] == 3'd7) ||
                                    (frame_i[2:0] == 3'd6 && !frame_i[FRAME_W-1]));

  // R3
  staged_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ref_div_i) || !$stable(modulus_i)) |-> $past(wr0_i));

  // R4
  read_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && frame_i[FRAME_W-1]) |=>
      ($stable(int_div_i) && $stable(phase_i) && $stable(ctl3_i) && $stable(ctl4_i)));

  // R8
  bad_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_addr |=> ($stable(int_div_i) && $stable(phase_i) && $stable(ctl3_i) && $stable(ctl4_i)));

  // R7
  por_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(por_i));

  // R9
  hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b0000) |-> !mux_oe_i);

  // R10
  rhalf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdiv_i) |=> (half_i[0] != $past(half_i[0])));

  // R10
  nhalf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ndiv_i) |=> (half_i[1] != $past(half_i[1])));
endmodule

bind cfg_serial_bank cfgsb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_vld_i (frame_vld),
  .frame_i     (frame_w),
  .wr0_i       (wr0),
  .sel_i       (mux_sel),
  .por_i       (por),
  .half_i      (half),
  .rdiv_i      (rdiv_i),
  .ndiv_i      (ndiv_i),
  .ref_div_i   (ref_div_o),
  .modulus_i   (modulus_o),
  .int_div_i   (int_div_o),
  .phase_i     (phase_o),
  .ctl3_i      (ctl3_o),
  .ctl4_i      (ctl4_o),
  .mux_oe_i    (mux_oe_o)
);

// File: tb/cfg_serial_bank_bench.sv
module cfg_serial_bank_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [6:0] adc = '0;
  logic adc_vld = 1'b0, rdiv = 1'b0, ndiv = 1'b0, lock = 1'b0, fastlock = 1'b0;
  logic mux, mux_oe, prescale, ref_dbl, ref_half, slip_red;
  logic [15:0] int_div;
  logic [11:0] frac, phase, modulus;
  logic [9:0]  ref_div;
  logic [1:0]  sd_mode;
  logic [3:0]  cp_cur;
  logic [27:0] ctl3, ctl4;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cfg_serial_bank u_cfg_serial_bank (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .sload_i(sload),
    .adc_i(adc), .adc_vld_i(adc_vld), .rdiv_i(rdiv), .ndiv_i(ndiv), .lock_i(lock),
    .fastlock_i(fastlock), .mux_o(mux), .mux_oe_o(mux_oe), .int_div_o(int_div),
    .frac_o(frac), .phase_o(phase), .prescale_o(prescale), .ref_div_o(ref_div),
    .ref_dbl_o(ref_dbl), .ref_half_o(ref_half), .modulus_o(modulus),
    .sd_mode_o(sd_mode), .slip_red_o(slip_red), .cp_cur_o(cp_cur),
    .ctl3_o(ctl3), .ctl4_o(ctl4)
  );

  localparam logic [31:0] W0 = (32'd7 << 27) | (32'h123 << 15) | (32'h045 << 3);
  localparam logic [31:0] W1 = (32'hA << 27) | (32'd1 << 25) | (32'h15 << 15) | (32'h3C5 << 3) | 32'd1;
  localparam logic [31:0] W2 = (32'd2 << 29) | (32'd1 << 28) | (32'd5 << 24) | (32'd1 << 21) |
                               (32'h0B << 15) | (32'h7D0 << 3) | 32'd2;
  localparam logic [31:0] W3 = 32'h0ABC_DE5B;
  localparam logic [31:0] W4 = 32'h1234_5674;

  typedef struct packed {
    logic [2:0]  addr;
    logic [31:0] frame;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{addr: 3'd1, frame: W1},
    '{addr: 3'd2, frame: W2},
    '{addr: 3'd3, frame: W3},
    '{addr: 3'd4, frame: W4}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1; wait_clk(4);
    sclk = 1'b0; wait_clk(4);
  endtask

  task automatic send_frame(input logic [31:0] f);
    sload = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      sdata = f[i];
      wait_clk(1);
      pulse_sclk();
    end
    sload = 1'b1; wait_clk(6);
    sload = 1'b0; wait_clk(4);
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [28:0] v);
    send_frame({1'b1, 28'h0, a});
    v = '0;
    for (int i = 0; i < 29; i++) begin
      pulse_sclk();
      v = {v[27:0], mux};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [28:0] rb, exp_rb;
    logic [27:0] c3, c4;
    logic [15:0] nd;
    logic        h0;
    wait_clk(4);
    // R11 reset state
    chk(mux_oe == 1'b0, "R11 oe", 32'(mux_oe), 0);
    chk(int_div == 0 && frac == 0 && phase == 0, "R11 fields", 32'(int_div), 0);
    chk(ref_div == 0 && modulus == 0 && ctl3 == 0, "R11 staged", 32'(ref_div), 0);
    rst_ni = 1'b1;
    wait_clk(4);

    // R1 R2 word0 with readback selector
    send_frame(W0);
    chk(int_div == 16'h0123, "R2 int_div lo", 32'(int_div), 32'h0123);
    chk(frac == 12'h045, "R2 frac", 32'(frac), 32'h045);
    chk(mux_oe == 1'b1, "R9 oe spi", 32'(mux_oe), 1);

    // table walk: write, then read back each word (R1 R5)
    foreach (VECS[k]) begin
      send_frame(VECS[k].frame);
      read_reg(VECS[k].addr, rb);
      exp_rb = {1'b0, VECS[k].frame[30:3]};
      chk(rb == exp_rb, "R1/R5 readback", 32'(rb), 32'(exp_rb));
    end
    read_reg(3'd0, rb);
    chk(rb == {1'b0, W0[30:3]}, "R5 readback word0", 32'(rb), 32'({1'b0, W0[30:3]}));
    // R5 readback holds after the last bit
    pulse_sclk();
    chk(mux == W0[3], "R5 hold", 32'(mux), 32'(W0[3]));

    // R2 fields from word1/2
    chk(int_div == 16'hA123, "R2 int_div", 32'(int_div), 32'hA123);
    chk(phase == 12'h3C5, "R2 phase", 32'(phase), 32'h3C5);
    chk(prescale == 1'b1, "R2 prescale", 32'(prescale), 1);
    chk(sd_mode == 2'd2 && slip_red && cp_cur == 4'd5, "R2 word2 fields",
        32'({sd_mode, slip_red, cp_cur}), 32'({2'd2, 1'b1, 4'd5}));
    // R3 staged fields not yet active
    chk(ref_div == 0 && modulus == 0 && !ref_half, "R3 before word0", 32'(ref_div), 0);
    send_frame(W0);
    chk(ref_div == 10'h2AB, "R3 ref_div", 32'(ref_div), 32'h2AB);
    chk(modulus == 12'h7D0, "R3 modulus", 32'(modulus), 32'h7D0);
    chk(ref_half == 1'b1 && ref_dbl == 1'b0, "R3 dbl/half", 32'({ref_dbl, ref_half}), 32'b01);
    // R3 staged change, not yet applied
    send_frame((W2 & ~(32'hFFF << 3)) | (32'h100 << 3));
    chk(modulus == 12'h7D0, "R3 held modulus", 32'(modulus), 32'h7D0);
    send_frame(W2);

    // R4 read with junk payload keeps contents
    c3 = ctl3;
    send_frame(32'hFFFF_FFFB);
    for (int i = 0; i < 29; i++) pulse_sclk();
    chk(ctl3 == c3, "R4 ctl3 kept", 32'(ctl3), 32'(c3));
    read_reg(3'd3, rb);
    chk(rb == {1'b0, W3[30:3]}, "R4 readback after read", 32'(rb), 32'({1'b0, W3[30:3]}));

    // R8 ignored addresses
    c3 = ctl3; c4 = ctl4; nd = int_div;
    send_frame(32'h7FFF_FFFD);
    send_frame(32'h7FFF_FFFF);
    send_frame(32'h7FFF_FFFE);
    chk(ctl3 == c3 && ctl4 == c4, "R8 ctl kept", 32'(ctl4), 32'(c4));
    chk(int_div == nd && phase == 12'h3C5, "R8 fields kept", 32'(int_div), 32'(nd));
    read_reg(3'd5, rb);
    chk(rb == 29'h0 || rb == {29{W0[3]}}, "R8 no readback for 5", 32'(rb), 0);

    // R6 R7 status word
    adc = 7'h5A; adc_vld = 1'b1;
    wait_clk(2);
    read_reg(3'd6, rb);
    exp_rb = {20'h0, 1'b1, 1'b1, 7'h5A};
    chk(rb == exp_rb, "R6 status first", 32'(rb), 32'(exp_rb));
    adc_vld = 1'b0;
    read_reg(3'd6, rb);
    exp_rb = {20'h0, 1'b0, 1'b0, 7'h5A};
    chk(rb == exp_rb, "R7 por cleared", 32'(rb), 32'(exp_rb));

    // R9 selector decode
    send_frame((W0 & ~(32'hF << 27)) | (32'd3 << 27));
    rdiv = 1'b1; wait_clk(3);
    chk(mux == 1'b1 && mux_oe, "R9 rdiv high", 32'(mux), 1);
    rdiv = 1'b0; wait_clk(3);
    chk(mux == 1'b0, "R9 rdiv low", 32'(mux), 0);
    send_frame((W0 & ~(32'hF << 27)) | (32'd1 << 27));
    chk(mux == 1'b1, "R9 const high", 32'(mux), 1);
    send_frame((W0 & ~(32'hF << 27)) | (32'd12 << 27));
    fastlock = 1'b1; wait_clk(2);
    chk(mux == 1'b1, "R9 fastlock", 32'(mux), 1);
    send_frame((W0 & ~(32'hF << 27)) | (32'd8 << 27));
    chk(mux_oe == 1'b0, "R9 sync oe low", 32'(mux_oe), 0);
    send_frame(W0 & ~(32'hF << 27));
    chk(mux_oe == 1'b0, "R9 hiz", 32'(mux_oe), 0);

    // R10 halved divider outputs
    send_frame((W0 & ~(32'hF << 27)) | (32'd13 << 27));
    h0 = mux;
    rdiv = 1'b1; wait_clk(3); rdiv = 1'b0; wait_clk(3);
    chk(mux == ~h0, "R10 rhalf toggle", 32'(mux), 32'(~h0));
    rdiv = 1'b1; wait_clk(3); rdiv = 1'b0; wait_clk(3);
    chk(mux == h0, "R10 rhalf back", 32'(mux), 32'(h0));
    send_frame((W0 & ~(32'hF << 27)) | (32'd14 << 27));
    h0 = mux;
    ndiv = 1'b1; wait_clk(3); ndiv = 1'b0; wait_clk(3);
    chk(mux == ~h0, "R10 nhalf toggle", 32'(mux), 32'(~h0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule